// File: doc/BRIEF.md
# Interrupt Mask and Priority Register Bank

This block is the software-visible register store of an interrupt controller. It holds a set of mask registers, with one bit per interrupt source, and a set of priority registers, with a multi-bit field per source. Each register has a pair of address slots. One slot is the set alias and the other is the clear alias. A parameter per register decides which of the two slots are decoded. A mask register with both aliases is updated by OR-ing data into it or by clearing bits out of it. A register with only one decoded alias, and every priority register, takes the written word as its new contents.

After each accepted write, the block walks the fields of the written register one per clock cycle, starting with the most significant field. For every field whose value changed, it raises an event on that cycle. The event carries the interrupt source number and whether the new field is nonzero. Downstream logic uses these events to keep per-source enable state without polling. While the walk runs, the block reports busy and drops any further write.

Top module: `prio_mask_bank`

## Requirements
- R1: Bits 31..29 of `addr_i` are ignored. Only bits 28..0 are compared against the register addresses. Register r has its set alias at BASE_ADDR + 8·r and its clear alias at BASE_ADDR + 8·r + 4. Mask registers come first (r = 0..NUM_MASK-1), then the priority registers.
- R2: For a mask register whose mode is 0 (both aliases decoded), a write to the set alias stores old | wdata.
- R3: For a mask register in mode 0, a write to the clear alias stores old & ~wdata.
- R4: A register in mode 1 decodes only its set alias, and one in mode 2 decodes only its clear alias. In either mode a write stores wdata unchanged. A priority register stores wdata unchanged through any decoded alias.
- R5: Fields are numbered from 0. Field k of a register with F fields of width W occupies bits starting at (F-1-k)·W. Mask fields are 1 bit wide, so F = 32. Priority fields are PRIO_FW bits wide, so F = 32/PRIO_FW. Field k is examined in the k-th cycle (counting from 0) after the edge that accepted the write. Its source number is r·32 + k for a mask register, and NUM_MASK·32 + (r-NUM_MASK)·F + k for a priority register.
- R6: `evt_valid_o` is high in a scan cycle only when the field's old and new values differ. In that cycle, `evt_en_o` is 1 exactly when the new field value is nonzero. Outside a scan, `evt_valid_o` is low.
- R7: A write to a decoded alias while `busy_o` is low is accepted. `busy_o` is then high for exactly F cycles. Writes presented while `busy_o` is high, and writes to undecoded addresses, change no register and start no scan.
- R8: `rdata_o` combinationally returns the stored value of the register whose decoded alias `addr_i` selects, and returns zero for any other address.
- R9: An active-low asynchronous reset `rst_ni` clears every register, ends any scan, and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Byte address for read and write |
| wdata_i | input | REG_W | Write data |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| rdata_o | output | REG_W | Read data for `addr_i` |
| busy_o | output | 1 | Field scan in progress; writes are dropped |
| evt_valid_o | output | 1 | A field changed in this scan cycle |
| evt_src_o | output | SRC_W | Source number of the changed field |
| evt_en_o | output | 1 | New field value is nonzero |

## Verification
A wrong stored value is visible on `rdata_o` as soon as the written alias is read back, which is the cycle after the accepting edge. A wrong merge through a set or clear alias, or a missed top-bit mask in the decoder, therefore appears within one cycle. A scan with the wrong field order, shift or source base shows up on the event outputs in the very cycle that should carry the field. This means a wrong source number, a spurious event or a missing event is caught in that cycle. A miscounted scan length or a write that slips through during busy changes when `busy_o` falls, and it changes later read-back values. Both are checked at the end of every scan.

// File: rtl/prio_mask_bank_pkg.sv
package prio_mask_bank_pkg;
  // per-register alias decoding
  typedef enum logic [1:0] {
    MODE_DUAL     = 2'd0,
    MODE_SET_ONLY = 2'd1,
    MODE_CLR_ONLY = 2'd2
  } alias_mode_e;
endpackage

// File: rtl/pmb_addr_decode.sv
module pmb_addr_decode
  import prio_mask_bank_pkg::*;
#(
  parameter int unsigned NUM_MASK   = 3,
  parameter int unsigned NUM_PRIO   = 2,
  parameter logic [28:0] BASE_ADDR  = 29'h100,
  parameter logic [2*NUM_MASK-1:0] MASK_MODES = '0,
  parameter logic [2*NUM_PRIO-1:0] PRIO_MODES = '0,
  localparam int unsigned NREG   = NUM_MASK + NUM_PRIO,
  localparam int unsigned RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [28:0]       addr_i,
  output logic              hit_o,
  output logic [RIDX_W-1:0] idx_o,
  output logic              clr_alias_o,
  output alias_mode_e       mode_o
);
  alias_mode_e     mode_w [NREG];
  logic [NREG-1:0] hit_set, hit_clr;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r < NUM_MASK) begin : g_mask
      assign mode_w[r] = alias_mode_e'(MASK_MODES[2*r +: 2]);
    end else begin : g_prio
      assign mode_w[r] = alias_mode_e'(PRIO_MODES[2*(r-NUM_MASK) +: 2]);
    end
    assign hit_set[r] = (mode_w[r] != MODE_CLR_ONLY) && (addr_i == 29'(BASE_ADDR + 8*r));
    assign hit_clr[r] = (mode_w[r] != MODE_SET_ONLY) && (addr_i == 29'(BASE_ADDR + 8*r + 4));
  end

  always_comb begin
    hit_o       = 1'b0;
    idx_o       = '0;
    clr_alias_o = 1'b0;
    mode_o      = MODE_DUAL;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (hit_set[r] || hit_clr[r]) begin
        hit_o       = 1'b1;
        idx_o       = RIDX_W'(r);
        clr_alias_o = hit_clr[r];
        mode_o      = mode_w[r];
      end
    end
  end
endmodule

// File: rtl/pmb_update.sv
module pmb_update
  import prio_mask_bank_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic [REG_W-1:0] old_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             is_prio_i,
  input  alias_mode_e      mode_i,
  input  logic             clr_alias_i,
  output logic [REG_W-1:0] new_o
);
  always_comb begin
    if (!is_prio_i && mode_i == MODE_DUAL)
      new_o = clr_alias_i ? (old_i & ~wdata_i) : (old_i | wdata_i);
    else
      new_o = wdata_i;
  end
endmodule

// File: rtl/pmb_field_scan.sv
module pmb_field_scan #(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned PRIO_FW = 4,
  parameter int unsigned SRC_W   = 7,
  localparam int unsigned PRIO_NF = REG_W / PRIO_FW,
  localparam int unsigned CNT_W   = $clog2(REG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [REG_W-1:0] old_i,
  input  logic [REG_W-1:0] new_i,
  input  logic             is_prio_i,
  input  logic [SRC_W-1:0] src_base_i,
  output logic             busy_o,
  output logic             evt_valid_o,
  output logic [SRC_W-1:0] evt_src_o,
  output logic             evt_en_o
);
  logic [REG_W-1:0] old_q, new_q, fmask, old_f, new_f;
  logic [SRC_W-1:0] base_q;
  logic [CNT_W-1:0] cnt_q, last_w;
  logic             prio_q, busy_q;
  int unsigned      sh;

  always_comb begin
    last_w = prio_q ? CNT_W'(PRIO_NF - 1) : CNT_W'(REG_W - 1);
    fmask  = prio_q ? REG_W'((1 << PRIO_FW) - 1) : REG_W'(1);
    sh     = (int'(last_w) - int'(cnt_q)) * (prio_q ? PRIO_FW : 1);
    old_f  = (old_q >> sh) & fmask;
    new_f  = (new_q >> sh) & fmask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q  <= '0;
      new_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      prio_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      old_q  <= old_i;
      new_q  <= new_i;
      base_q <= src_base_i;
      prio_q <= is_prio_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == last_w) busy_q <= 1'b0;
      else                 cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign evt_valid_o = busy_q && (old_f != new_f);
  assign evt_src_o   = base_q + SRC_W'(cnt_q);
  assign evt_en_o    = |new_f;
endmodule

// File: rtl/prio_mask_bank.sv
module prio_mask_bank
  import prio_mask_bank_pkg::*;
#(
  parameter int unsigned NUM_MASK  = 3,
  parameter int unsigned NUM_PRIO  = 2,
  parameter int unsigned REG_W     = 32,
  parameter int unsigned PRIO_FW   = 4,
  parameter logic [28:0] BASE_ADDR = 29'h100,
  parameter logic [2*NUM_MASK-1:0] MASK_MODES = 6'b10_01_00,
  parameter logic [2*NUM_PRIO-1:0] PRIO_MODES = 4'b01_00,
  localparam int unsigned NREG    = NUM_MASK + NUM_PRIO,
  localparam int unsigned RIDX_W  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned PRIO_NF = REG_W / PRIO_FW,
  localparam int unsigned NSRC    = NUM_MASK * REG_W + NUM_PRIO * PRIO_NF,
  localparam int unsigned SRC_W   = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             wr_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             busy_o,
  output logic             evt_valid_o,
  output logic [SRC_W-1:0] evt_src_o,
  output logic             evt_en_o
);
  logic [REG_W-1:0]  regs_q [NREG];
  logic [REG_W-1:0]  cur_val, new_val;
  logic [SRC_W-1:0]  src_base;
  logic [RIDX_W-1:0] idx;
  logic              hit, clr_alias, is_prio, wr_acc, busy;
  alias_mode_e       mode;

  pmb_addr_decode #(
    .NUM_MASK(NUM_MASK), .NUM_PRIO(NUM_PRIO), .BASE_ADDR(BASE_ADDR),
    .MASK_MODES(MASK_MODES), .PRIO_MODES(PRIO_MODES)
  ) u_dec (
    .addr_i(addr_i[28:0]), .hit_o(hit), .idx_o(idx),
    .clr_alias_o(clr_alias), .mode_o(mode)
  );

  assign cur_val = hit ? regs_q[idx] : '0;
  assign is_prio = int'(idx) >= NUM_MASK;

  pmb_update #(.REG_W(REG_W)) u_upd (
    .old_i(cur_val), .wdata_i(wdata_i), .is_prio_i(is_prio),
    .mode_i(mode), .clr_alias_i(clr_alias), .new_o(new_val)
  );

  always_comb begin
    int b;
    if (is_prio) b = NUM_MASK * REG_W + (int'(idx) - NUM_MASK) * PRIO_NF;
    else         b = int'(idx) * REG_W;
    src_base = SRC_W'(b);
  end

  assign wr_acc = wr_i && hit && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
    end else if (wr_acc) begin
      regs_q[idx] <= new_val;
    end
  end

  pmb_field_scan #(.REG_W(REG_W), .PRIO_FW(PRIO_FW), .SRC_W(SRC_W)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(wr_acc),
    .old_i(cur_val), .new_i(new_val), .is_prio_i(is_prio),
    .src_base_i(src_base), .busy_o(busy), .evt_valid_o(evt_valid_o),
    .evt_src_o(evt_src_o), .evt_en_o(evt_en_o)
  );

  assign busy_o  = busy;
  assign rdata_o = cur_val;
endmodule

// File: rtl/prio_mask_bank_chk.sv
module prio_mask_bank_chk #(
  parameter int unsigned REG_W     = 32,
  parameter int unsigned NSRC      = 112,
  parameter int unsigned SRC_W     = 7,
  parameter logic [28:0] BASE_ADDR = 29'h100,
  parameter logic [1:0]  MODE0     = 2'd0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [31:0]      addr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic             wr_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             busy_o,
  input logic             evt_valid_o,
  input logic [SRC_W-1:0] evt_src_o
);
  localparam logic [28:0] SET0 = BASE_ADDR;
  localparam logic [28:0] CLR0 = 29'(BASE_ADDR + 4);

  assert_set_or_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE0 == 2'd0 && wr_i && !busy_o && addr_i[28:0] == SET0) |=>
    (addr_i[28:0] != SET0 || rdata_o == ($past(rdata_o) | $past(wdata_i))));

  assert_clr_andn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE0 == 2'd0 && wr_i && !busy_o && addr_i[28:0] == CLR0) |=>
    (addr_i[28:0] != CLR0 || rdata_o == ($past(rdata_o) & ~$past(wdata_i))));

  assert_src_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (int'(evt_src_o) < NSRC));

  assert_evt_in_scan_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> busy_o);

  assert_busy_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_i));

  assert_reset_idle_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !evt_valid_o));
endmodule

bind prio_mask_bank prio_mask_bank_chk #(
  .REG_W(REG_W), .NSRC(NSRC), .SRC_W(SRC_W),
  .BASE_ADDR(BASE_ADDR), .MODE0(MASK_MODES[1:0])
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_i(wr_i), .rdata_o(rdata_o), .busy_o(busy_o),
  .evt_valid_o(evt_valid_o), .evt_src_o(evt_src_o)
);

// File: tb/prio_mask_bank_bench.sv
`timescale 1ns/1ps
module prio_mask_bank_bench;
  localparam int NM = 3, NP = 2, NR = 5;
  localparam logic [31:0] BASE = 32'h100;

  logic        clk = 0, rst_ni = 0, wr_i = 0;
  logic [31:0] addr_i = 0, wdata_i = 0, rdata_o;
  logic        busy_o, evt_valid_o, evt_en_o;
  logic [6:0]  evt_src_o;
  int          errors = 0, checks = 0;
  bit          done = 0;
  logic [31:0] model [NR];

  always #10 clk = ~clk;

  prio_mask_bank u_prio_mask_bank (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rdata_o(rdata_o), .busy_o(busy_o),
    .evt_valid_o(evt_valid_o), .evt_src_o(evt_src_o), .evt_en_o(evt_en_o)
  );

  function automatic int mode_of(int r);
    case (r) 0: return 0; 1: return 1; 2: return 2; 3: return 0; default: return 1; endcase
  endfunction
  function automatic int nf(int r);  return (r < NM) ? 32 : 8; endfunction
  function automatic int fwd(int r); return (r < NM) ? 1 : 4;  endfunction
  function automatic int base_src(int r); return (r < NM) ? r*32 : NM*32 + (r-NM)*8; endfunction
  function automatic logic [31:0] fld(logic [31:0] v, int r, int k);
    return (v >> ((nf(r)-1-k)*fwd(r))) & ((32'd1 << fwd(r)) - 1);
  endfunction
  function automatic logic [31:0] upd(int r, logic [31:0] o, logic [31:0] w, bit clr);
    if (r < NM && mode_of(r) == 0) return clr ? (o & ~w) : (o | w);
    return w;
  endfunction
  function automatic logic [31:0] alias_addr(int r, bit clr, logic [2:0] top);
    return {top, 29'(BASE + 32'(r*8) + (clr ? 32'd4 : 32'd0))};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // accepted write + full scan check; optional intruding write during scan
  task automatic wr_reg(int r, bit clr, logic [31:0] d, logic [2:0] top, bit intrude);
    logic [31:0] o, n;
    o = model[r];
    n = upd(r, o, d, clr);
    @(negedge clk);
    addr_i = alias_addr(r, clr, top); wdata_i = d; wr_i = 1;
    @(negedge clk);
    wr_i = 0;
    model[r] = n;
    for (int k = 0; k < nf(r); k++) begin
      bit ch;
      if (intrude && k == 0) begin
        addr_i = alias_addr(0, 0, 3'b000); wdata_i = 32'hFFFF_FFFF; wr_i = 1;
      end else if (intrude && k == 1) begin
        wr_i = 0; addr_i = alias_addr(r, clr, top);
      end
      ch = fld(o, r, k) != fld(n, r, k);
      chk(busy_o == 1, "R7 busy in scan", 32'(busy_o), 1);
      chk(evt_valid_o == ch, "R6 event only on change", 32'(evt_valid_o), 32'(ch));
      if (ch) begin
        chk(int'(evt_src_o) == base_src(r) + k, "R5 source index", 32'(evt_src_o), 32'(base_src(r) + k));
        chk(evt_en_o == (fld(n, r, k) != 0), "R6 enable level", 32'(evt_en_o), 32'(fld(n, r, k) != 0));
      end
      @(negedge clk);
    end
    chk(busy_o == 0, "R7 scan length", 32'(busy_o), 0);
    chk(evt_valid_o == 0, "R6 idle no event", 32'(evt_valid_o), 0);
    #1 chk(rdata_o == n, "R2 R3 R4 stored value", rdata_o, n);
  endtask

  task automatic rd_chk(logic [31:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    addr_i = a; #1;
    chk(rdata_o == exp, req, rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int r = 0; r < NR; r++) model[r] = 0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && evt_valid_o == 0, "R9 idle in reset", {busy_o, evt_valid_o}, 0);
    rst_ni = 1;
    // R9/R8: reset state
    for (int r = 0; r < NR; r++) rd_chk(alias_addr(r, mode_of(r) == 2, 3'b000), 0, "R9 reset value");

    // directed: dual mask set/clear, R2 R3
    wr_reg(0, 0, 32'h8000_0001, 3'b000, 0);
    wr_reg(0, 0, 32'h0000_0100, 3'b111, 0);
    wr_reg(0, 1, 32'h8000_0000, 3'b010, 0);
    // R1: top bits ignored on read
    rd_chk(alias_addr(0, 1, 3'b101), model[0], "R1 top bits ignored");
    // R4: single-alias registers replace
    wr_reg(1, 0, 32'hF0F0_0000, 3'b000, 0);
    wr_reg(1, 0, 32'h0000_000F, 3'b000, 0);
    wr_reg(2, 1, 32'h1234_5678, 3'b000, 0);
    wr_reg(2, 1, 32'h0000_0000, 3'b000, 0);
    wr_reg(3, 0, 32'h1020_3040, 3'b000, 0);
    wr_reg(3, 1, 32'h0000_0001, 3'b000, 0);
    wr_reg(4, 0, 32'hF000_000F, 3'b000, 0);
    // R8: undecoded aliases read zero and accept no write
    rd_chk(alias_addr(1, 1, 3'b000), 0, "R8 set-only clear alias");
    rd_chk(alias_addr(2, 0, 3'b000), 0, "R8 clr-only set alias");
    rd_chk(32'h0000_0400, 0, "R8 unmapped");
    @(negedge clk); addr_i = alias_addr(2, 0, 3'b000); wdata_i = 32'hFFFF_FFFF; wr_i = 1;
    @(negedge clk); wr_i = 0;
    chk(busy_o == 0, "R7 undecoded write no scan", 32'(busy_o), 0);
    rd_chk(alias_addr(2, 1, 3'b000), model[2], "R7 undecoded write ignored");
    // R7: write while busy dropped
    wr_reg(3, 0, 32'h8765_4321, 3'b000, 1);
    rd_chk(alias_addr(0, 0, 3'b000), model[0], "R7 write during busy ignored");

    // random
    for (int i = 0; i < 150; i++) begin
      int r; bit c; logic [31:0] d;
      r = int'($urandom % NR);
      c = (mode_of(r) == 2) ? 1'b1 : (mode_of(r) == 1) ? 1'b0 : 1'($urandom);
      d = (r < NM) ? ($urandom & $urandom & $urandom) : $urandom;
      wr_reg(r, c, d, 3'($urandom), 0);
    end

    // R9: async reset mid-scan
    @(negedge clk); addr_i = alias_addr(4, 0, 3'b000); wdata_i = 32'hFFFF_FFFF; wr_i = 1;
    @(negedge clk); wr_i = 0;
    rst_ni = 0; #1;
    chk(busy_o == 0 && evt_valid_o == 0, "R9 reset ends scan", {busy_o, evt_valid_o}, 0);
    @(negedge clk); rst_ni = 1;
    for (int r = 0; r < NR; r++) model[r] = 0;
    for (int r = 0; r < NR; r++) rd_chk(alias_addr(r, mode_of(r) == 2, 3'b000), 0, "R9 cleared");
    wr_reg(3, 1, 32'h0000_0050, 3'b000, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule